// File: doc/BRIEF.md
# Quad-Precision Compare with Condition-Code Update

This block compares two 128-bit IEEE binary floating-point operands and writes the two-bit relation into one of four condition-code fields of a 64-bit floating-point status word. A quiet variant reports unordered results silently unless an operand is a signaling NaN. A signaling variant flags every unordered result as invalid. The block produces the updated status word and a five-bit exception vector for a separate exception recorder. It makes no trap decisions itself. The only trap-related input is a control pin that tells it to leave the status word alone when invalid is raised.

A request (both operands, the field selector, the variant flag, the inhibit control and the current status word) enters on a valid/ready handshake and is taken on any edge where `in_valid` and `in_ready` are both high. The response sits in a one-entry output register. It appears the cycle after acceptance and is presented with `out_valid`. When `out_ready` is low the response and `out_valid` hold, and `in_ready` drops. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Under continuous readiness the block therefore takes one compare per cycle. The field selector is the low two bits of the compare's destination register number.

Top module: `qcmp_fcc_unit`

## Requirements
- R1: A request is accepted on a rising edge with `in_valid` and `in_ready` high, and `out_valid` is high after that edge. `in_ready` equals `!out_valid || out_ready`. After reset `out_valid` is 0 and `in_ready` is 1.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `fsr_out` and `exc_flags` hold, and no new request is taken.
- R3: The relation code is 0 for equal, 1 when operand A is less than B, 2 when A is greater than B, and 3 for unordered. Ordered operands, infinities included, compare by numeric value.
- R4: Positive zero and negative zero compare equal (code 0) and raise nothing in either variant.
- R5: When the signs differ and the operands are not both zero, the negative operand is less. When both are negative, the larger magnitude is the lesser value.
- R6: An operand with exponent bits 126:112 all ones and a nonzero fraction in bits 111:0 is a NaN, and any NaN operand gives code 3. A NaN whose bit 111 is 1 is quiet, and a quiet compare involving only quiet NaNs raises nothing.
- R7: In the signaling variant (`signaling`=1), an unordered result sets invalid, which is `exc_flags[4]`. An ordered result raises nothing.
- R8: A NaN with bit 111 equal to 0 is signaling. If either operand is one, invalid is set even in the quiet variant.
- R9: The selector value picks where the code is written: 0 writes status bits 11:10, 1 writes bits 33:32, 2 writes bits 35:34, and 3 writes bits 37:36. Every other status bit equals `fsr_in` as sampled at acceptance.
- R10: When `inhibit_on_invalid` is 1 and invalid is raised, `fsr_out` equals the sampled `fsr_in`. When invalid is not raised, the code is written as in R9 regardless of that pin.
- R11: `exc_flags[3:0]` is always 0 in a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| opnd_a | input | 128 | First operand (A) |
| opnd_b | input | 128 | Second operand (B) |
| fcc_sel | input | 2 | Condition-code field selector |
| signaling | input | 1 | 1 = signaling variant, 0 = quiet variant |
| inhibit_on_invalid | input | 1 | Keep status unchanged when invalid is raised |
| fsr_in | input | 64 | Current status word |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response this cycle |
| fsr_out | output | 64 | Updated status word |
| exc_flags | output | 5 | Exception vector, bit 4 = invalid |

## Verification
The case hardest to reach from the ports is a new request waiting at the input while a stalled response sits in the output register. That stall must change nothing, and the release edge must retire the old response and take the new request together. The bench holds `out_ready` low across several cycles with a second compare already driven. It checks that the first response is frozen, then raises `out_ready` and checks that the second result appears on the very next cycle. The signaling-NaN cases combined with the inhibit pin are the other narrow path. They are reached by pairing a signaling NaN with an ordinary operand in the quiet variant, with and without inhibit.

// File: rtl/qcmp_pkg.sv
package qcmp_pkg;
  localparam int QW      = 128;
  localparam int EW      = 15;
  localparam int FW      = QW - EW - 1;
  localparam int SW      = 64;
  localparam int XW      = 5;
  localparam int INV_BIT = 4;
  localparam int NFCC    = 4;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic          sign;
    logic          is_nan;
    logic          is_snan;
    logic          is_zero;
    logic [QW-2:0] mag;
  } opnd_info_t;

  // Low bit of the status-word field chosen by a selector value.
  function automatic int unsigned fcc_lsb(input logic [1:0] sel);
    return (sel == 2'd0) ? 10 : (30 + 2 * int'(sel));
  endfunction
endpackage

// File: rtl/qcmp_classify.sv
module qcmp_classify
  import qcmp_pkg::*;
#(
  parameter int W  = QW,
  parameter int E  = EW
) (
  input  logic [W-1:0] val,
  output opnd_info_t   info
);
  localparam int F = W - E - 1;

  logic [E-1:0] expo;
  logic [F-1:0] frac;

  assign expo = val[W-2 -: E];
  assign frac = val[F-1:0];

  always_comb begin
    info.sign    = val[W-1];
    info.mag     = val[W-2:0];
    info.is_zero = ~|val[W-2:0];
    info.is_nan  = (&expo) & (|frac);
    info.is_snan = (&expo) & (|frac) & ~frac[F-1];
  end
endmodule

// File: rtl/qcmp_order.sv
module qcmp_order
  import qcmp_pkg::*;
(
  input  opnd_info_t a_info,
  input  opnd_info_t b_info,
  output rel_e       rel
);
  logic mag_gt;
  logic mag_eq;

  assign mag_gt = a_info.mag > b_info.mag;
  assign mag_eq = a_info.mag == b_info.mag;

  always_comb begin
    if (a_info.is_nan || b_info.is_nan) begin
      rel = REL_UN;
    end else if (a_info.is_zero && b_info.is_zero) begin
      rel = REL_EQ;
    end else if (a_info.sign != b_info.sign) begin
      rel = a_info.sign ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else if (a_info.sign) begin
      rel = mag_gt ? REL_LT : REL_GT;
    end else begin
      rel = mag_gt ? REL_GT : REL_LT;
    end
  end
endmodule

// File: rtl/qcmp_fcc_merge.sv
module qcmp_fcc_merge
  import qcmp_pkg::*;
(
  input  logic [SW-1:0] fsr_in,
  input  logic [1:0]    sel,
  input  rel_e          rel,
  input  logic          keep,
  output logic [SW-1:0] fsr_out
);
  logic [NFCC-1:0] hit;

  for (genvar g = 0; g < NFCC; g++) begin : g_hit
    assign hit[g] = (sel == g[1:0]) & ~keep;
  end

  always_comb begin
    fsr_out = fsr_in;
    for (int f = 0; f < NFCC; f++) begin
      if (hit[f]) fsr_out[fcc_lsb(f[1:0]) +: 2] = rel;
    end
  end
endmodule

// File: rtl/qcmp_fcc_unit.sv
module qcmp_fcc_unit
  import qcmp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [QW-1:0] opnd_a,
  input  logic [QW-1:0] opnd_b,
  input  logic [1:0]    fcc_sel,
  input  logic          signaling,
  input  logic          inhibit_on_invalid,
  input  logic [SW-1:0] fsr_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] fsr_out,
  output logic [XW-1:0] exc_flags
);
  opnd_info_t    info [2];
  logic [QW-1:0] opnd [2];
  rel_e          rel;
  logic          invalid;
  logic [SW-1:0] fsr_next;
  logic          accept;

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    qcmp_classify #(.W(QW), .E(EW)) u_cls (
      .val  (opnd[i]),
      .info (info[i])
    );
  end

  qcmp_order u_ord (
    .a_info (info[0]),
    .b_info (info[1]),
    .rel    (rel)
  );

  assign invalid = (rel == REL_UN) &
                   (signaling | info[0].is_snan | info[1].is_snan);

  qcmp_fcc_merge u_mrg (
    .fsr_in  (fsr_in),
    .sel     (fcc_sel),
    .rel     (rel),
    .keep    (invalid & inhibit_on_invalid),
    .fsr_out (fsr_next)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fsr_out   <= '0;
      exc_flags <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      fsr_out   <= fsr_next;
      exc_flags <= XW'(invalid) << INV_BIT;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/qcmp_fcc_unit_chk.sv
module qcmp_fcc_unit_chk
  import qcmp_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    fcc_sel,
  input logic          inhibit_on_invalid,
  input logic [SW-1:0] fsr_in,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] fsr_out,
  input logic [XW-1:0] exc_flags
);
  logic [SW-1:0] cap_fsr;
  logic [1:0]    cap_sel;
  logic          cap_inh;
  logic [SW-1:0] cap_mask;
  logic [1:0]    sel_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_fsr <= '0;
      cap_sel <= '0;
      cap_inh <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_fsr <= fsr_in;
      cap_sel <= fcc_sel;
      cap_inh <= inhibit_on_invalid;
    end
  end

  assign cap_mask  = SW'(3) << fcc_lsb(cap_sel);
  assign sel_field = fsr_out[fcc_lsb(cap_sel) +: 2];

  assert_resp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(fsr_out) && $stable(exc_flags)));

  assert_invalid_unordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_flags[INV_BIT] && !cap_inh) |-> (sel_field == 2'b11));

  assert_outside_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((fsr_out ^ cap_fsr) & ~cap_mask) == '0));

  assert_inhibit_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_inh && exc_flags[INV_BIT]) |-> (fsr_out == cap_fsr));

  assert_exc_low_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (exc_flags[3:0] == 4'b0));
endmodule

bind qcmp_fcc_unit qcmp_fcc_unit_chk u_chk (.*);

// File: tb/sim_qcmp_fcc_unit.sv
module sim_qcmp_fcc_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] opnd_a = '0;
  logic [127:0] opnd_b = '0;
  logic [1:0]   fcc_sel = '0;
  logic         signaling = 1'b0;
  logic         inhibit_on_invalid = 1'b0;
  logic [63:0]  fsr_in = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  fsr_out;
  logic [4:0]   exc_flags;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  qcmp_fcc_unit u0 (.*);

  localparam logic [127:0] ONE   = {1'b0, 15'h3FFF, 112'b0};
  localparam logic [127:0] TWO   = {1'b0, 15'h4000, 112'b0};
  localparam logic [127:0] NONE  = {1'b1, 15'h3FFF, 112'b0};
  localparam logic [127:0] NTWO  = {1'b1, 15'h4000, 112'b0};
  localparam logic [127:0] PZERO = 128'b0;
  localparam logic [127:0] NZERO = {1'b1, 127'b0};
  localparam logic [127:0] PINF  = {1'b0, 15'h7FFF, 112'b0};
  localparam logic [127:0] QNAN  = {1'b0, 15'h7FFF, 1'b1, 111'b0};
  localparam logic [127:0] SNAN  = {1'b0, 15'h7FFF, 1'b0, 110'b0, 1'b1};
  localparam logic [63:0]  PAT1  = 64'hA5A5_5A5A_F0F0_0F0F;
  localparam logic [63:0]  PAT2  = 64'h0123_4567_89AB_CDEF;

  function automatic logic [63:0] put(input logic [63:0] f, input logic [1:0] s,
                                      input logic [1:0] r);
    logic [63:0] o = f;
    case (s)
      2'd0: o[11:10] = r;
      2'd1: o[33:32] = r;
      2'd2: o[35:34] = r;
      default: o[37:36] = r;
    endcase
    return o;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] a, input logic [127:0] b, input logic [1:0] s,
                       input logic sg, input logic inh, input logic [63:0] f);
    opnd_a = a; opnd_b = b; fcc_sel = s; signaling = sg;
    inhibit_on_invalid = inh; fsr_in = f; in_valid = 1'b1;
  endtask

  task automatic do_cmp(input string tag, input logic [127:0] a, input logic [127:0] b,
                        input logic [1:0] s, input logic sg, input logic inh,
                        input logic [63:0] f, input logic [1:0] rel, input logic inv);
    @(negedge clk);
    drive(a, b, s, sg, inh, f);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " fsr"}, fsr_out, (inv && inh) ? f : put(f, s, rel));
    chk({tag, " exc R11"}, 64'(exc_flags), {59'b0, inv, 4'b0});
  endtask

  task automatic t_reset();
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
    chk("R1 reset in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_ordered();
    do_cmp("R3 R9 one<two sel0", ONE, TWO, 2'd0, 1'b0, 1'b0, PAT1, 2'd1, 1'b0);
    do_cmp("R3 R9 two>one sel1", TWO, ONE, 2'd1, 1'b0, 1'b0, PAT1, 2'd2, 1'b0);
    do_cmp("R3 R9 one==one sel2", ONE, ONE, 2'd2, 1'b1, 1'b0, PAT2, 2'd0, 1'b0);
    do_cmp("R3 R9 inf>two sel3", PINF, TWO, 2'd3, 1'b1, 1'b0, ~PAT2, 2'd2, 1'b0);
  endtask

  task automatic t_zero();
    do_cmp("R4 +0==-0", PZERO, NZERO, 2'd1, 1'b0, 1'b0, PAT2, 2'd0, 1'b0);
    do_cmp("R4 -0==+0 sig", NZERO, PZERO, 2'd3, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF,
           2'd0, 1'b0);
  endtask

  task automatic t_sign();
    do_cmp("R5 -1<1", NONE, ONE, 2'd0, 1'b0, 1'b0, PAT1, 2'd1, 1'b0);
    do_cmp("R5 -2<-1", NTWO, NONE, 2'd2, 1'b0, 1'b0, PAT1, 2'd1, 1'b0);
    do_cmp("R5 -1>-2", NONE, NTWO, 2'd1, 1'b0, 1'b0, PAT2, 2'd2, 1'b0);
    do_cmp("R5 1>-2", ONE, NTWO, 2'd3, 1'b0, 1'b0, PAT2, 2'd2, 1'b0);
    do_cmp("R5 -0>-1", NZERO, NONE, 2'd0, 1'b0, 1'b0, PAT2, 2'd2, 1'b0);
  endtask

  task automatic t_nan();
    do_cmp("R6 qnan quiet", QNAN, ONE, 2'd0, 1'b0, 1'b0, PAT1, 2'd3, 1'b0);
    do_cmp("R7 qnan signaling", ONE, QNAN, 2'd1, 1'b1, 1'b0, PAT1, 2'd3, 1'b1);
    do_cmp("R8 snan A quiet", SNAN, ONE, 2'd2, 1'b0, 1'b0, PAT2, 2'd3, 1'b1);
    do_cmp("R8 snan B quiet", ONE, SNAN, 2'd3, 1'b0, 1'b0, PAT2, 2'd3, 1'b1);
  endtask

  task automatic t_inhibit();
    do_cmp("R10 snan inhibited", SNAN, ONE, 2'd1, 1'b0, 1'b1, PAT1, 2'd3, 1'b1);
    do_cmp("R10 qnan sig inhibited", QNAN, QNAN, 2'd0, 1'b1, 1'b1, PAT2, 2'd3, 1'b1);
    do_cmp("R10 no invalid writes", ONE, TWO, 2'd2, 1'b0, 1'b1, PAT1, 2'd1, 1'b0);
    do_cmp("R10 qnan quiet writes", QNAN, TWO, 2'd3, 1'b0, 1'b1, PAT1, 2'd3, 1'b0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    drive(ONE, TWO, 2'd0, 1'b0, 1'b0, PAT1);
    @(posedge clk);
    @(negedge clk);
    drive(TWO, ONE, 2'd1, 1'b0, 1'b0, PAT2);
    chk("R1 stalled in_ready", 64'(in_ready), 64'd0);
    chk("R2 first result", fsr_out, put(PAT1, 2'd0, 2'd1));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 still valid", 64'(out_valid), 64'd1);
    chk("R2 held result", fsr_out, put(PAT1, 2'd0, 2'd1));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 second valid", 64'(out_valid), 64'd1);
    chk("R1 second result", fsr_out, put(PAT2, 2'd1, 2'd2));
    @(posedge clk);
    @(negedge clk);
    chk("R1 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_ordered();
    t_zero();
    t_sign();
    t_nan();
    t_inhibit();
    t_backpressure();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule